// File: doc/BRIEF.md
# Coincidence Event Trigger with Busy Rejection

The block builds one event trigger out of four candidate sources: a thinned copy of a fast timing scintillator ("singles"), the coincidence of that scintillator with a secondary detector, and two external trigger lines. A per-source enable mask picks any subset of the four. The enabled sources are ORed into the raw trigger. The raw trigger only becomes a live trigger while the block is not busy.

Each live trigger latches an event request level for the host and ORs the sources that fired into a pattern word. After a fixed delay, the raw trigger sets a busy latch. Busy then blocks further events until the host, having read the event, pulses a clear. A small coincidence register records which of the four input lines showed an edge within a programmable window after the trigger. The lines reach this register through the same fixed delay.

All four inputs are asynchronous. Each one is synchronized and reduced to a single rising-edge pulse before any logic uses it.

Top module: `coinc_trigger`

## Requirements
- R1: After reset, busy, the event request, the pattern word and the coincidence register are all zero.
- R2: The coincidence source fires once when the scintillator and secondary-detector inputs become high together. The secondary input alone never produces an event.
- R3: With downscale value N, the singles source fires on every Nth scintillator edge. N = 1 passes every edge, and N = 0 never fires.
- R4: The raw trigger is the OR of the sources whose enable bit is set. A firing source whose enable bit is clear produces no event.
- R5: While busy is set, no source can change the pattern word or produce a new event.
- R6: Busy rises exactly DLY clock cycles after the event request rises, and stays set until a host clear.
- R7: The event request is a level. Once set, it stays set until a host clear.
- R8: The pattern word uses bit 0 for singles, bit 1 for coincidence, bit 2 for external 0 and bit 3 for external 1. It ORs together the enabled sources of every live trigger accepted before busy rises.
- R9: A host clear zeroes busy, the event request, the pattern word and the coincidence register. It wins over a trigger arriving in the same cycle, and that trigger leaves no later busy.
- R10: The coincidence register uses bit 0 for the scintillator, bit 1 for the secondary detector, and bits 2 and 3 for the external lines. An input edge that arrives together with the live trigger is recorded only when the gate length is at least DLY.
- R11: An input held high counts as one edge. It causes no further event after a host clear while it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scint_in | input | 1 | Timing scintillator signal (asynchronous) |
| aux_in | input | 1 | Secondary detector signal (asynchronous) |
| ext_in | input | 2 | External trigger lines (asynchronous) |
| src_en | input | 4 | Source enable mask, bit order as the pattern word |
| dscale_n | input | DSW | Singles downscale factor |
| gate_len | input | GW | Coincidence gate length in cycles |
| host_clr | input | 1 | Host clear pulse |
| raw_trig | output | 1 | OR of enabled source pulses |
| live_trig | output | 1 | Raw trigger not blocked by busy |
| busy | output | 1 | Busy latch |
| evt_req | output | 1 | Latched event request |
| pattern | output | 4 | Trigger pattern word |
| coinc_reg | output | 4 | Coincidence register |

## Verification
The bench uses the default DLY = 2, DSW = 8 and GW = 8. This puts the busy-delay window within reach: two sources can arrive one cycle apart and both land in the pattern before busy rises. It also puts the gate boundary within reach, since gate lengths 1 and 2 sit on either side of the delay. Downscale values 0, 1 and 3 cover the disabled case, the pass-through case and a real thinning case. An 8-bit counter reaches all three within a few pulses.

// File: rtl/coinc_trigger.sv
module coinc_trigger #(
  parameter int DLY = 2,
  parameter int DSW = 8,
  parameter int GW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scint_in,
  input  logic           aux_in,
  input  logic [1:0]     ext_in,
  input  logic [3:0]     src_en,
  input  logic [DSW-1:0] dscale_n,
  input  logic [GW-1:0]  gate_len,
  input  logic           host_clr,
  output logic           raw_trig,
  output logic           live_trig,
  output logic           busy,
  output logic           evt_req,
  output logic [3:0]     pattern,
  output logic [3:0]     coinc_reg
);

  logic [3:0] in_a, in_b, in_c, edg, src;
  logic [DSW-1:0] ds_cnt;
  logic [GW-1:0] gate_cnt;
  logic [DLY-1:0] raw_pipe;
  logic [3:0] dly_q [DLY];
  logic co_p, sing_p, ds_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_a <= '0; in_b <= '0; in_c <= '0;
    end else begin
      in_a <= {ext_in, aux_in, scint_in};
      in_b <= in_a;
      in_c <= in_b;
    end
  end

  assign edg    = in_b & ~in_c;
  assign co_p   = (in_b[0] & in_b[1]) & ~(in_c[0] & in_c[1]);
  assign ds_hit = ({1'b0, ds_cnt} + 1'b1) >= {1'b0, dscale_n};
  assign sing_p = edg[0] && (dscale_n != '0) && ds_hit;
  assign src    = {edg[3], edg[2], co_p, sing_p};
  assign raw_trig  = |(src & src_en);
  assign live_trig = raw_trig & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) ds_cnt <= '0;
    else if (edg[0] && dscale_n != '0) ds_cnt <= ds_hit ? '0 : ds_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || host_clr) begin
      raw_pipe <= '0;
      busy     <= 1'b0;
      evt_req  <= 1'b0;
      pattern  <= '0;
    end else begin
      raw_pipe[0] <= raw_trig;
      for (int i = 1; i < DLY; i++) raw_pipe[i] <= raw_pipe[i-1];
      if (raw_pipe[DLY-1]) busy <= 1'b1;
      if (live_trig) begin
        evt_req <= 1'b1;
        pattern <= pattern | (src & src_en);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DLY; i++) dly_q[i] <= '0;
    end else begin
      dly_q[0] <= edg;
      for (int i = 1; i < DLY; i++) dly_q[i] <= dly_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || host_clr) begin
      gate_cnt  <= '0;
      coinc_reg <= '0;
    end else begin
      if (live_trig) gate_cnt <= gate_len;
      else if (gate_cnt != '0) gate_cnt <= gate_cnt - 1'b1;
      if (gate_cnt != '0) coinc_reg <= coinc_reg | dly_q[DLY-1];
    end
  end

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !host_clr |=> busy);
  // R6
  busy_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> evt_req);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_req && !host_clr |=> evt_req);
  // R5
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !host_clr |=> $stable(pattern) && $stable(evt_req));
  // R8
  pat_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pattern != '0 |-> evt_req);
  // R9
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_clr |=> !busy && !evt_req && pattern == '0 && coinc_reg == '0);
  // R10
  coinc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coinc_reg & ~$past(coinc_reg)) != '0 |-> $past(gate_cnt != '0));

endmodule

// File: tb/coinc_trigger_tb.sv
module coinc_trigger_tb;
  localparam int DLY = 2;
  logic clk = 0, rst_n = 0;
  logic scint_in = 0, aux_in = 0, host_clr = 0;
  logic [1:0] ext_in = 0;
  logic [3:0] src_en = 4'hF;
  logic [7:0] dscale_n = 8'd1, gate_len = 8'd0;
  logic raw_trig, live_trig, busy, evt_req;
  logic [3:0] pattern, coinc_reg;
  int n_chk = 0, n_fail = 0;
  logic [3:0] exp_q[$];
  logic busy_d = 0;

  always #10 clk = ~clk;

  coinc_trigger u_dut (.clk(clk), .rst_n(rst_n), .scint_in(scint_in), .aux_in(aux_in),
    .ext_in(ext_in), .src_en(src_en), .dscale_n(dscale_n), .gate_len(gate_len),
    .host_clr(host_clr), .raw_trig(raw_trig), .live_trig(live_trig), .busy(busy),
    .evt_req(evt_req), .pattern(pattern), .coinc_reg(coinc_reg));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pattern settles once busy rises
  always @(negedge clk) begin
    if (rst_n && busy && !busy_d) begin
      if (exp_q.size() == 0) chk("R8 unexpected event", {28'd0, pattern}, 32'hFFFF);
      else chk("R8 pattern", {28'd0, pattern}, {28'd0, exp_q.pop_front()});
      chk("R7 req at busy", {31'd0, evt_req}, 1);
    end
    busy_d <= busy;
  end

  task automatic drive(logic [3:0] m, int hold);
    @(negedge clk);
    {ext_in, aux_in, scint_in} = m;
    repeat (hold) @(negedge clk);
    {ext_in, aux_in, scint_in} = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic clear();
    @(negedge clk); host_clr = 1;
    @(negedge clk); host_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 req", {31'd0, evt_req}, 0);
    chk("R1 pattern", {28'd0, pattern}, 0);
    chk("R1 coinc", {28'd0, coinc_reg}, 0);

    exp_q.push_back(4'b0001); drive(4'b0001, 3);
    chk("R3 N=1 req", {31'd0, evt_req}, 1); clear();
    exp_q.push_back(4'b0011); drive(4'b0011, 3); clear();
    drive(4'b0010, 3);
    chk("R2 aux alone", {31'd0, evt_req}, 0);
    exp_q.push_back(4'b0100); drive(4'b0100, 3); clear();
    exp_q.push_back(4'b1000); drive(4'b1000, 3); clear();

    src_en = 4'b0010;
    drive(4'b0001, 3); chk("R4 masked singles", {31'd0, evt_req}, 0);
    drive(4'b0100, 3); chk("R4 masked ext0", {28'd0, pattern}, 0);

    src_en = 4'b0001; dscale_n = 3;
    drive(4'b0001, 3); chk("R3 N=3 first", {31'd0, evt_req}, 0);
    drive(4'b0001, 3); chk("R3 N=3 second", {31'd0, evt_req}, 0);
    exp_q.push_back(4'b0001); drive(4'b0001, 3);
    chk("R3 N=3 third", {31'd0, evt_req}, 1); clear();
    dscale_n = 0;
    drive(4'b0001, 3); drive(4'b0001, 3);
    chk("R3 N=0", {31'd0, evt_req}, 0);

    src_en = 4'hF; dscale_n = 1;
    exp_q.push_back(4'b0001);
    @(negedge clk); scint_in = 1;
    begin
      int cyc = 0;
      while (!evt_req) @(negedge clk);
      while (!busy && cyc < 10) begin @(negedge clk); cyc++; end
      chk("R6 busy delay", cyc, DLY);
    end
    scint_in = 0;
    drive(4'b0100, 3);
    chk("R5 pattern while busy", {28'd0, pattern}, 4'b0001);
    repeat (20) @(negedge clk);
    chk("R6 busy held", {31'd0, busy}, 1);
    clear();
    chk("R9 cleared busy", {31'd0, busy}, 0);
    chk("R9 cleared req", {31'd0, evt_req}, 0);

    exp_q.push_back(4'b1001);
    @(negedge clk); scint_in = 1;
    @(negedge clk); ext_in[1] = 1;
    repeat (3) @(negedge clk); scint_in = 0; ext_in = 0;
    repeat (6) @(negedge clk); clear();

    exp_q.push_back(4'b0100);
    @(negedge clk); ext_in[0] = 1;
    repeat (12) @(negedge clk);
    clear();
    repeat (8) @(negedge clk);
    chk("R11 held level", {31'd0, evt_req}, 0);
    ext_in = 0; repeat (4) @(negedge clk);

    @(negedge clk); ext_in[0] = 1;
    @(negedge clk);
    @(negedge clk); host_clr = 1;
    @(negedge clk); host_clr = 0;
    repeat (6) @(negedge clk);
    chk("R9 priority busy", {31'd0, busy}, 0);
    chk("R9 priority req", {31'd0, evt_req}, 0);
    ext_in = 0; repeat (4) @(negedge clk);

    gate_len = 2; exp_q.push_back(4'b0011); drive(4'b0011, 3);
    chk("R10 gate=DLY", {28'd0, coinc_reg}, 4'b0011); clear();
    chk("R9 coinc cleared", {28'd0, coinc_reg}, 0);
    gate_len = 1; exp_q.push_back(4'b0011); drive(4'b0011, 3);
    chk("R10 gate<DLY", {28'd0, coinc_reg}, 0); clear();

    repeat (4) @(negedge clk);
    chk("R8 queue drained", exp_q.size(), 0);
    summary();
  end
endmodule